// File: doc/BRIEF.md
# Serial Control Register Receiver

This block is a write-only slave on a three-wire serial control bus made of a data line, a mode line and a clock line. A controller first sends an address byte while the mode line is low. That byte names a device and picks one of two register groups. The controller then raises the mode line and sends value bytes. In each value byte, the top two bits choose a register inside the selected group and the low six bits are the value written into it. The registers configure an audio converter. The data group holds items such as volume, de-emphasis and mute. The status group holds the system clock rate and the input format.

All three serial lines are asynchronous to the system clock. Each line passes through a two-stage synchronizer, and the system clock oversamples it. The system clock must run at least four times faster than the serial clock. Bits are taken on rising edges of the serial clock, least significant bit first. A register changes only when a whole byte has been received. The register contents come out as two flat parallel buses. There is no read path.

Top module: `sctl_rx`

## Requirements
- R1: After reset no device is selected and every register reads zero, except data-group register 2 (mute), which reads 6'h01 (muted).
- R2: A byte is sent least significant bit first, one bit per serial clock rising edge. With the mode line low it is an address byte, and it selects the block when bits 7:2 equal 6'b000101. An address byte never changes a register.
- R3: After an address byte whose bits 1:0 are 2'b00, each byte sent with the mode line high writes its bits 5:0 into data-group register number bits 7:6. Data-group register k appears on dataRegs[6k+5:6k].
- R4: After an address byte whose bits 1:0 are 2'b10, value bytes write the status group in the same way. Status register k appears on statRegs[6k+5:6k].
- R5: After an address byte whose bits 1:0 are 2'b01 or 2'b11, value bytes leave both groups unchanged.
- R6: An address byte with any other device field deselects the block. All later value bytes are ignored until a matching address byte arrives.
- R7: An accepted address stays in effect for any number of value bytes that follow.
- R8: Any change of the mode line discards the bits collected so far. An interrupted byte changes nothing, not even the device selection, and the next byte is assembled from a fresh bit count.
- R9: A value byte of which only seven bits have arrived leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| serData | input | 1 | Serial data line, asynchronous |
| serMode | input | 1 | Mode line: low for address bytes, high for value bytes |
| serClk | input | 1 | Serial clock, data taken on its rising edge |
| dataRegs | output | 24 | Data-group registers 0..3, six bits each, register 0 in the low bits |
| statRegs | output | 24 | Status-group registers 0..3, six bits each, register 0 in the low bits |

## Verification
The assertions assume the controller holds the serial clock at each level for at least four system cycles. They also assume the data and mode lines are stable around every rising edge, so a write strobe always follows a serial clock that was already high and a mode line that was already high three cycles earlier. The driver keeps each serial clock phase four system cycles long. It changes data only while the serial clock is low, and it changes the mode line only between bytes, with a four-cycle gap. Partial bytes are made by moving the mode line after fewer than eight bits.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int BYTE_W  = 8;
  localparam int VAL_W   = 6;
  localparam int IDX_W   = 2;
  localparam int REG_CNT = 1 << IDX_W;
  localparam int ID_W    = 6;
  localparam int GRP_W   = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_DATA  = 2'b00,
    GRP_SKIP1 = 2'b01,
    GRP_STAT  = 2'b10,
    GRP_SKIP3 = 2'b11
  } grp_e;

  // write strobes from control to the register bank
  typedef struct packed {
    logic             wrData;
    logic             wrStat;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
  } wr_stb_t;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [ID_W-1:0] DEV_ID      = 6'b000101
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serData,
  input  logic    serMode,
  input  logic    serClk,
  output wr_stb_t stb
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic             clkS, datS, modeS;
  logic             clkPrev, modePrev;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic             devSel;
  grp_e             grp;

  sctl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({serClk, serData, serMode}),
    .dout ({clkS, datS, modeS})
  );

  logic              rise, modeChg, lastBit;
  logic [BYTE_W-1:0] full;

  always_comb begin
    rise    = clkS & ~clkPrev;
    modeChg = modeS ^ modePrev;
    lastBit = rise && (bitCnt == LAST_BIT);
    full    = {datS, shReg[BYTE_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      modePrev <= 1'b0;
      bitCnt   <= '0;
      shReg    <= '0;
      devSel   <= 1'b0;
      grp      <= GRP_SKIP1;
      stb      <= '0;
    end else begin
      clkPrev  <= clkS;
      modePrev <= modeS;
      stb      <= '0;
      if (modeChg) begin
        bitCnt <= '0;
      end else if (rise) begin
        shReg  <= full;
        bitCnt <= bitCnt + 1'b1;
        if (lastBit) begin
          if (!modeS) begin
            devSel <= (full[BYTE_W-1:GRP_W] == DEV_ID);
            grp    <= grp_e'(full[GRP_W-1:0]);
          end else if (devSel) begin
            stb.wrData <= (grp == GRP_DATA);
            stb.wrStat <= (grp == GRP_STAT);
            stb.idx    <= full[BYTE_W-1:VAL_W];
            stb.val    <= full[VAL_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/sctl_dpath.sv
module sctl_dpath
  import sctl_pkg::*;
#(
  parameter int               MUTE_IDX = 2,
  parameter logic [VAL_W-1:0] MUTE_RST = 6'h01
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wr_stb_t                  stb,
  output logic [REG_CNT*VAL_W-1:0] dataRegs,
  output logic [REG_CNT*VAL_W-1:0] statRegs
);
  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    localparam logic [VAL_W-1:0] D_RST = (g == MUTE_IDX) ? MUTE_RST : '0;
    logic [VAL_W-1:0] dq, sq;
    logic             hit;

    assign hit = (stb.idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dq <= D_RST;
        sq <= '0;
      end else begin
        if (stb.wrData && hit) dq <= stb.val;
        if (stb.wrStat && hit) sq <= stb.val;
      end
    end

    assign dataRegs[g*VAL_W +: VAL_W] = dq;
    assign statRegs[g*VAL_W +: VAL_W] = sq;
  end
endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
  import sctl_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ID_W-1:0]  DEV_ID      = 6'b000101,
  parameter int               MUTE_IDX    = 2,
  parameter logic [VAL_W-1:0] MUTE_RST    = 6'h01
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serData,
  input  logic                     serMode,
  input  logic                     serClk,
  output logic [REG_CNT*VAL_W-1:0] dataRegs,
  output logic [REG_CNT*VAL_W-1:0] statRegs
);
  wr_stb_t stb;

  sctl_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DEV_ID(DEV_ID)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serData (serData),
    .serMode (serMode),
    .serClk  (serClk),
    .stb     (stb)
  );

  sctl_dpath #(.MUTE_IDX(MUTE_IDX), .MUTE_RST(MUTE_RST)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dataRegs (dataRegs),
    .statRegs (statRegs)
  );
endmodule

// File: rtl/sctl_rx_chk.sv
module sctl_rx_chk
  import sctl_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     serClk,
  input logic                     serMode,
  input wr_stb_t                  stb,
  input logic [REG_CNT*VAL_W-1:0] dataRegs,
  input logic [REG_CNT*VAL_W-1:0] statRegs
);
  // R9: registers move only in the cycle after a strobe
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.wrData) |-> $stable(dataRegs));
  a_r9_stat_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.wrStat) |-> $stable(statRegs));

  // R3 / R4: a strobe lands in the named register
  a_r3_data_lands: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.wrData) |->
      dataRegs[int'($past(stb.idx))*VAL_W +: VAL_W] == $past(stb.val));
  a_r4_stat_lands: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.wrStat) |->
      statRegs[int'($past(stb.idx))*VAL_W +: VAL_W] == $past(stb.val));

  // R2: writes follow a serial clock rising edge
  a_r2_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrData || stb.wrStat) |-> $past(serClk, 3));

  // R3: writes only come from bytes sent with the mode line high
  a_r3_in_value_mode: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrData || stb.wrStat) |-> $past(serMode, 3));

  // R1: no strobe is issued while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !(stb.wrData || stb.wrStat));
endmodule

bind sctl_rx sctl_rx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .serClk   (serClk),
  .serMode  (serMode),
  .stb      (stb),
  .dataRegs (dataRegs),
  .statRegs (statRegs)
);

// File: tb/sctl_rx_tb.sv
module sctl_rx_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serData = 1'b0;
  logic        serMode = 1'b0;
  logic        serClk = 1'b0;
  logic [23:0] dataRegs, statRegs;

  always #4 clk = ~clk;

  sctl_rx u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .serData  (serData),
    .serMode  (serMode),
    .serClk   (serClk),
    .dataRegs (dataRegs),
    .statRegs (statRegs)
  );

  typedef struct {
    logic [47:0] exp;
    string       tag;
    int          due;
  } item_t;

  item_t      q[$];
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;
  bit         done = 0;
  logic [5:0] expData [4];
  logic [5:0] expStat [4];
  logic       sel;
  logic [1:0] grp;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected snapshots when due and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && cyc >= q[0].due) begin
        item_t it;
        it = q.pop_front();
        total++;
        if ({statRegs, dataRegs} !== it.exp) begin
          bad++;
          $display("FAIL %s: actual stat=%h data=%h expected stat=%h data=%h",
                   it.tag, statRegs, dataRegs, it.exp[47:24], it.exp[23:0]);
        end
      end
    end
  end

  function automatic logic [47:0] snap();
    logic [47:0] v;
    for (int k = 0; k < 4; k++) begin
      v[k*6 +: 6]      = expData[k];
      v[24 + k*6 +: 6] = expStat[k];
    end
    return v;
  endfunction

  task automatic expectNow(input string tag);
    q.push_back('{exp: snap(), tag: tag, due: cyc + 2});
    repeat (4) @(negedge clk);
  endtask

  task automatic sendBits(input logic mode, input logic [7:0] b, input int n);
    serMode = mode;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      serData = b[i];
      serClk  = 1'b0;
      repeat (4) @(negedge clk);
      serClk  = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  // reference model taken from the requirements
  task automatic sendByte(input logic mode, input logic [7:0] b, input string tag);
    sendBits(mode, b, 8);
    if (!mode) begin
      sel = (b[7:2] == 6'b000101);
      grp = b[1:0];
    end else if (sel) begin
      if (grp == 2'b00) expData[b[7:6]] = b[5:0];
      else if (grp == 2'b10) expStat[b[7:6]] = b[5:0];
    end
    expectNow(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      expData[k] = '0;
      expStat[k] = '0;
    end
    expData[2] = 6'h01;
    sel = 1'b0;
    grp = 2'b01;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expectNow("R1 reset values");

    // R2: value byte before any address is ignored, then address select
    sendByte(1'b1, 8'h2A, "R2 no device selected yet");
    sendByte(1'b0, 8'h14, "R2 address byte changes nothing");
    // R3: data group writes
    sendByte(1'b1, 8'h2A, "R3 data reg0 = 2A");
    sendByte(1'b1, 8'h80, "R3 data reg2 unmute");
    // R7: selection persists
    sendByte(1'b1, 8'hFF, "R7 data reg3 = 3F");
    sendByte(1'b1, 8'h53, "R7 data reg1 = 13");
    // R4: status group
    sendByte(1'b0, 8'h16, "R4 status address");
    sendByte(1'b1, 8'h55, "R4 status reg1 = 15");
    sendByte(1'b1, 8'h0C, "R4 status reg0 = 0C");
    sendByte(1'b1, 8'hE1, "R4 status reg3 = 21");
    // R5: unused selectors
    sendByte(1'b0, 8'h15, "R5 selector 01");
    sendByte(1'b1, 8'h41, "R5 selector 01 discards");
    sendByte(1'b0, 8'h17, "R5 selector 11");
    sendByte(1'b1, 8'hC7, "R5 selector 11 discards");
    // R6: wrong device ids
    sendByte(1'b0, 8'h24, "R6 foreign id 001001");
    sendByte(1'b1, 8'h11, "R6 ignored while deselected");
    sendByte(1'b0, 8'hFC, "R6 foreign id 111111");
    sendByte(1'b1, 8'h33, "R6 still ignored");
    sendByte(1'b0, 8'h14, "R6 reselect");
    sendByte(1'b1, 8'h11, "R6 write after reselect");
    // R9: seven bits only
    sendBits(1'b1, 8'h7F, 7);
    expectNow("R9 seven bits no write");
    // R8: mode change drops partial byte
    sendBits(1'b0, 8'h00, 0);
    expectNow("R8 partial dropped");
    sendByte(1'b1, 8'h45, "R8 fresh byte after abort");
    // R8: partial foreign address does not deselect
    sendBits(1'b0, 8'h24, 5);
    sendByte(1'b1, 8'hC9, "R8 partial address keeps selection");

    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule